// File: doc/BRIEF.md
# Serial Trace Line Transmitter

This block holds fixed-width trace lines in a circular buffer and sends them out one bit per bus clock on a single serial data pin. A companion profiling clock changes level once in the middle of every bit period, so an external capture device can sample the data pin on both edges of that clock with half a bus cycle of setup and hold margin. The lines are opaque words; their content is not interpreted.

Lines enter through a valid/ready write port. `wr_ready` is a capture enable, not flow control: it is high while the block is armed and no overflow has occurred. A producer that sees `wr_ready` high must not wait. Any cycle with `wr_valid` and `wr_ready` both high is a write. If the buffer is already full, that write is dropped and flagged as an overflow. When `wr_ready` is low, `wr_valid` is ignored.

Serial output overlaps with incoming writes. A line is moved from the buffer into the shifter only in a cycle with no write. Once armed capture ends, whether by disarm or by overflow, the remaining lines still drain. `tx_active` reports that lines are still pending.

Top module: `trace_prof_tx`

## Requirements
- R1: Each line is sent least significant bit first, one bit per bus clock, for LINE_W consecutive cycles on `sdo`. `sdo` is 0 whenever no line is being shifted.
- R2: `pclk` changes level exactly once in each bit period, on the falling bus clock edge in the middle of that period.
- R3: A line starts shifting only on an edge where no write occurs. Its bit 0 appears on `sdo` in the cycle after that edge.
- R4: Writes are accepted while a line is being shifted. When the next line is stored and the final bit cycle of the current line has no write, the next line follows with no idle cycle.
- R5: While no line is being shifted, `pclk` holds its level.
- R6: `tx_active` is high while any line is stored or being shifted. It stays high after disarm until every stored line has been sent.
- R7: A write while DEPTH lines are stored drops the line and sets `tx_ovf`. `tx_ovf` stays set, and `wr_ready` stays low, until it is cleared as in R9. Dropped lines are never sent.
- R8: `wr_ready` equals `arm` high and `tx_ovf` low. When `wr_ready` is low, `wr_valid` has no effect.
- R9: A rising edge of `arm` while `tx_active` is low clears `tx_ovf` and resets the buffer pointers. A rising edge while `tx_active` is high leaves `tx_ovf` unchanged.
- R10: After reset, `sdo`, `pclk`, `tx_active` and `tx_ovf` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm | input | 1 | Armed level; capture is enabled while high |
| wr_valid | input | 1 | Write strobe for a trace line |
| wr_ready | output | 1 | Capture enable (armed and no overflow) |
| wr_data | input | LINE_W | Trace line |
| sdo | output | 1 | Serial data, LSB first |
| pclk | output | 1 | Profiling clock, one level change per bit |
| tx_active | output | 1 | Lines stored or being shifted |
| tx_ovf | output | 1 | Sticky buffer overflow flag |

## Verification
The checker watches several rules on every edge: one `pclk` change per shifted bit and none between lines, `sdo` low while idle, no line start right after a write, `tx_active` covering the shifter, overflow stickiness while disarmed, and the `wr_ready` gating. Other properties span long sequences and are left to the bench scenarios. These are exact LSB-first bit order across many lines, gap-free back-to-back lines, draining after disarm, a full 64-line overflow, and the difference between re-arming while draining and re-arming when idle. The bench model predicts every output on every cycle.

// File: rtl/trace_prof_pkg.sv
package trace_prof_pkg;
  typedef enum logic {
    SHF_IDLE  = 1'b0,
    SHF_SHIFT = 1'b1
  } shf_state_e;
endpackage

// File: rtl/tpt_fifo.sv
module tpt_fifo #(
  parameter int W     = 64,
  parameter int DEPTH = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW:0]   fill;

  assign full  = (fill == (AW+1)'(DEPTH));
  assign empty = (fill == '0);
  assign dout  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end
endmodule

// File: rtl/tpt_shifter.sv
module tpt_shifter #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] line,
  output logic         sdo,
  output logic         busy,
  output logic         last
);
  import trace_prof_pkg::*;
  localparam int CW = $clog2(W);

  shf_state_e    state;
  logic [W-1:0]  sh;
  logic [CW-1:0] bit_idx;

  assign busy = (state == SHF_SHIFT);
  assign last = busy && (bit_idx == CW'(W-1));
  assign sdo  = sh[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= SHF_IDLE;
      sh      <= '0;
      bit_idx <= '0;
    end else if (load) begin
      state   <= SHF_SHIFT;
      sh      <= line;
      bit_idx <= '0;
    end else if (busy) begin
      sh      <= sh >> 1;
      bit_idx <= bit_idx + 1'b1;
      if (last) state <= SHF_IDLE;
    end
  end
endmodule

// File: rtl/tpt_pclk_gen.sv
module tpt_pclk_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic pclk
);
  // Falling-edge register: level changes half a bus cycle after data launch.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n)  pclk <= 1'b0;
    else if (en) pclk <= ~pclk;
  end
endmodule

// File: rtl/trace_prof_tx.sv
module trace_prof_tx #(
  parameter int LINE_W = 64,
  parameter int DEPTH  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [LINE_W-1:0] wr_data,
  output logic              sdo,
  output logic              pclk,
  output logic              tx_active,
  output logic              tx_ovf
);
  logic              arm_q, arm_rise, rearm_clr;
  logic              wr_fire, fifo_push, fifo_pop;
  logic              fifo_full, fifo_empty;
  logic [LINE_W-1:0] fifo_dout;
  logic              shf_busy, shf_last, shf_load;

  assign wr_ready  = arm && !tx_ovf;
  assign wr_fire   = wr_valid && wr_ready;
  assign fifo_push = wr_fire && !fifo_full;
  assign shf_load  = (!shf_busy || shf_last) && !fifo_empty && !wr_fire;
  assign fifo_pop  = shf_load;
  assign tx_active = shf_busy || !fifo_empty;
  assign arm_rise  = arm && !arm_q;
  assign rearm_clr = arm_rise && !tx_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q  <= 1'b0;
      tx_ovf <= 1'b0;
    end else begin
      arm_q <= arm;
      if (rearm_clr)                  tx_ovf <= 1'b0;
      else if (wr_fire && fifo_full)  tx_ovf <= 1'b1;
    end
  end

  tpt_fifo #(.W(LINE_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .clr(rearm_clr),
    .push(fifo_push), .pop(fifo_pop), .din(wr_data),
    .dout(fifo_dout), .full(fifo_full), .empty(fifo_empty)
  );

  tpt_shifter #(.W(LINE_W)) u_shf (
    .clk(clk), .rst_n(rst_n), .load(shf_load), .line(fifo_dout),
    .sdo(sdo), .busy(shf_busy), .last(shf_last)
  );

  tpt_pclk_gen u_pclk (
    .clk(clk), .rst_n(rst_n), .en(shf_busy), .pclk(pclk)
  );
endmodule

// File: rtl/trace_prof_tx_chk.sv
module trace_prof_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic arm,
  input logic wr_valid,
  input logic wr_ready,
  input logic sdo,
  input logic pclk,
  input logic tx_active,
  input logic tx_ovf,
  input logic busy
);
  AST_SDO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sdo); // R1
  AST_PCLK_EDGE_PER_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (pclk != $past(pclk))); // R2
  AST_NO_START_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> !$rose(busy)); // R3
  AST_PCLK_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> $stable(pclk)); // R5
  AST_ACTIVE_COVERS_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> tx_active); // R6
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ovf && !arm) |=> tx_ovf); // R7
  AST_NO_ACCEPT_AFTER_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ovf |-> !wr_ready); // R7
  AST_READY_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    !arm |-> !wr_ready); // R8
endmodule

bind trace_prof_tx trace_prof_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .arm(arm), .wr_valid(wr_valid),
  .wr_ready(wr_ready), .sdo(sdo), .pclk(pclk), .tx_active(tx_active),
  .tx_ovf(tx_ovf), .busy(shf_busy)
);

// File: tb/test_trace_prof_tx.sv
module test_trace_prof_tx;
  localparam int CLK_P = 10;
  localparam int LW    = 64;
  localparam int DEP   = 64;

  logic          clk = 1'b0, rst_n = 1'b0, arm = 1'b0, wr_valid = 1'b0;
  logic [LW-1:0] wr_data = '0;
  logic          wr_ready, sdo, pclk, tx_active, tx_ovf;

  trace_prof_tx #(.LINE_W(LW), .DEPTH(DEP)) i_trace_prof_tx (
    .clk(clk), .rst_n(rst_n), .arm(arm), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_data(wr_data), .sdo(sdo), .pclk(pclk),
    .tx_active(tx_active), .tx_ovf(tx_ovf)
  );

  always #(CLK_P/2) clk = ~clk;

  int n_cmp = 0, n_bad = 0, n_tog = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  logic [LW-1:0] q[$];
  bit            m_busy, m_ovf, m_armq, m_pclk;
  logic [LW-1:0] m_sh;
  int            m_left;

  always @(posedge clk) begin : model
    bit fire, start, act;
    if (!rst_n) begin
      q.delete(); m_busy = 0; m_ovf = 0; m_armq = 0; m_sh = '0; m_left = 0;
    end else begin
      fire  = wr_valid && arm && !m_ovf;
      act   = m_busy || (q.size() > 0);
      start = (!m_busy || m_left == 1) && (q.size() > 0) && !fire;
      if (m_busy) begin
        m_sh = m_sh >> 1;
        m_left--;
        if (m_left == 0) m_busy = 0;
      end
      if (start) begin
        m_sh = q.pop_front(); m_left = LW; m_busy = 1;
      end
      if (fire) begin
        if (q.size() >= DEP) m_ovf = 1;
        else q.push_back(wr_data);
      end
      if (arm && !m_armq && !act) m_ovf = 0;
      m_armq = arm;
    end
  end

  always @(negedge clk) begin
    if (!rst_n) m_pclk = 0;
    else if (m_busy) m_pclk = ~m_pclk;
  end

  always @(pclk) if (rst_n) n_tog++;

  always @(posedge clk) begin
    #(CLK_P*3/4);
    if (rst_n) begin
      chk(sdo == (m_busy ? m_sh[0] : 1'b0), "R1 sdo", 64'(sdo), 64'(m_busy ? m_sh[0] : 1'b0));
      chk(pclk == m_pclk, "R2/R5 pclk", 64'(pclk), 64'(m_pclk));
      chk(tx_active == (m_busy || q.size() > 0), "R6 tx_active", 64'(tx_active), 64'(m_busy || q.size() > 0));
      chk(tx_ovf == m_ovf, "R7 tx_ovf", 64'(tx_ovf), 64'(m_ovf));
      chk(wr_ready == (arm && !m_ovf), "R8 wr_ready", 64'(wr_ready), 64'(arm && !m_ovf));
    end
  end

  function automatic logic [63:0] mk(input int i);
    return {32'(i) * 32'h9E3779B9, ~32'(i) ^ 32'h5A5A0F0F};
  endfunction

  task automatic tick();
    @(posedge clk); #(CLK_P/4);
  endtask

  task automatic put(input logic [63:0] d);
    wr_valid = 1'b1; wr_data = d; tick(); wr_valid = 1'b0;
  endtask

  task automatic drain();
    for (int g = 0; g < 20000 && tx_active; g++) tick();
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_P*200000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    finish_run();
  end

  initial begin
    int t0;
    repeat (3) @(posedge clk);
    #(CLK_P/4); rst_n = 1'b1;
    tick();
    // R10: reset state
    chk(!sdo && !pclk && !tx_active && !tx_ovf, "R10 reset outputs",
        {60'd0, sdo, pclk, tx_active, tx_ovf}, 64'd0);

    // R8: writes while disarmed are ignored
    for (int i = 0; i < 3; i++) put(mk(100 + i));
    tick();
    chk(!tx_active, "R8 disarmed write ignored", 64'(tx_active), 64'd0);

    // R3: no start in a write cycle
    arm = 1'b1; tick();
    t0 = n_tog;
    put(mk(1)); put(mk(2));
    #(CLK_P/2);
    chk(n_tog == t0 && !sdo, "R3 no start during write", 64'(n_tog - t0), 64'd0);
    tick(); #(CLK_P/2);
    chk(n_tog == t0 + 1, "R3 start after write-free cycle", 64'(n_tog - t0), 64'd1);
    #(CLK_P/4);
    drain();
    chk(n_tog == t0 + 2*LW, "R4 back-to-back lines", 64'(n_tog - t0), 64'(2*LW));

    // R4: writes interleaved with shifting, incl. near line boundaries
    put(mk(3));
    for (int i = 0; i < 6; i++) begin
      repeat (37 + 13*i) tick();
      put(mk(10 + i));
    end
    for (int k = 0; k < 5; k++) begin
      repeat (LW - 2 + k) tick();
      put(mk(20 + k));
    end
    drain();

    // R6: disarm while draining
    t0 = n_tog;
    for (int i = 0; i < 4; i++) put(mk(30 + i));
    arm = 1'b0; tick();
    chk(tx_active && !wr_ready, "R6 active after disarm", {62'd0, tx_active, wr_ready}, 64'd2);
    drain();
    chk(n_tog == t0 + 4*LW, "R6 all lines sent after disarm", 64'(n_tog - t0), 64'(4*LW));

    // R7: overflow
    arm = 1'b1; tick();
    t0 = n_tog;
    wr_valid = 1'b1;
    for (int i = 0; i < DEP + 3; i++) begin wr_data = mk(200 + i); tick(); end
    wr_valid = 1'b0;
    chk(tx_ovf && !wr_ready, "R7 overflow flagged", {62'd0, tx_ovf, wr_ready}, 64'd2);
    // R9: re-arm while draining keeps the flag
    arm = 1'b0; tick(); arm = 1'b1; tick();
    chk(tx_ovf == 1'b1, "R9 re-arm while active ignored", 64'(tx_ovf), 64'd1);
    drain();
    chk(n_tog == t0 + DEP*LW, "R7 dropped lines not sent", 64'(n_tog - t0), 64'(DEP*LW));
    arm = 1'b0; tick(); arm = 1'b1; tick();
    chk(!tx_ovf && wr_ready, "R9 re-arm when idle clears", {62'd0, tx_ovf, wr_ready}, 64'd1);

    put(mk(77)); drain();
    repeat (4) tick();
    finish_run();
  end
endmodule